// File: doc/BRIEF.md
# Prescaled 16x Baud Tick Generator

This block makes the timing strobes for a serial transmitter and receiver from the system clock. It has two programmable stages in series. A narrow prescaler divides the clock. A wider divider then counts the prescaler's strobes. The divider's output is a one-cycle enable that comes at sixteen times the serial bit rate. A four-bit counter of those enables gives a second strobe once per bit time.

Both moduli come from one 12-bit rate word written through a plain register-style port. Each field holds its modulus minus one, so the oversampling rate is `clk / ((pre + 1) * (div + 1))` and the bit rate is that value divided by 16. For example, a 48 MHz clock with both fields zero gives 3 Mbit/s, and divider field 0x0F gives 187.5 kbit/s. The write port has no back-pressure: a write is accepted on every cycle where `rate_we` is high. It is a control pin pair, not a stream. The two strobes are free-running and have no handshake. Consumers sample them as clock enables.

Top module: `baud_tick_gen`

## Requirements
- R1: When `rate_we` is high at a rising clock edge, `rate_wdata` is stored. Bits 11:8 are the prescaler field `pre` and bits 7:0 are the divider field `div`.
- R2: With no write, `tick16_o` is high for exactly one cycle in every period of P = (pre+1)*(div+1) clock cycles.
- R3: With `pre`=0 and `div`=0, `tick16_o` is high on every clock cycle.
- R4: A write restarts all counters. Count the cycle after the capturing edge as cycle 0. `tick16_o` stays low in cycles 0 to P-2 and is first high in cycle P-1, with P taken from the new word.
- R5: `bit_tick_o` is high only together with `tick16_o`, on every 16th `tick16_o` pulse. After a write or a reset it first rises in cycle 16*P-1.
- R6: Reset clears all counters and sets the rate word to zero. From the first cycle after reset, `tick16_o` is high every cycle and `bit_tick_o` is first high in cycle 15.
- R7: The largest word, 0xFFF, gives a period of 4096 clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_we | input | 1 | Rate word write strobe |
| rate_wdata | input | 12 | Rate word: pre in 11:8, div in 7:0 |
| tick16_o | output | 1 | One-cycle enable at 16x the bit rate |
| bit_tick_o | output | 1 | One-cycle enable at the bit rate |

## Verification
The hardest case to reach is the restart. The old divider state has to be thrown away in mid-period and the first new strobe has to land exactly one full new period after the write. Each scenario therefore writes a new word while the old word is still counting, then counts the low cycles up to the first strobe and measures the next full interval. The bit strobe is checked the same way, and the longest setting is measured end to end.

// File: rtl/baud_pkg.sv
package baud_pkg;
  localparam int PRE_W = 4;
  localparam int DIV_W = 8;
  localparam int OVS   = 16;
endpackage

// File: rtl/baud_stage.sv
module baud_stage #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] limit,
  output logic         term
);
  logic [W-1:0] cnt;

  assign term = en && (cnt == limit);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (clr)    cnt <= '0;
    else if (en)     cnt <= (cnt == limit) ? '0 : cnt + 1'b1;
  end

  // R4: a restart leaves the stage at zero
  assert_restart_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr) |-> (cnt == '0));

  // R2: the count never passes its modulus
  assert_count_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= limit);
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_pkg::*;
#(
  parameter int PW  = PRE_W,
  parameter int DW  = DIV_W,
  parameter int OV  = OVS,
  localparam int CW = PW + DW,
  localparam int BW = $clog2(OV)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rate_we,
  input  logic [CW-1:0] rate_wdata,
  output logic          tick16_o,
  output logic          bit_tick_o
);
  localparam logic [BW-1:0] BIT_LAST = BW'(OV - 1);

  logic [CW-1:0] rate_q;
  logic          pre_en;

  always_ff @(posedge clk) begin
    if (!rst_n)       rate_q <= '0;
    else if (rate_we) rate_q <= rate_wdata;
  end

  baud_stage #(.W(PW)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr(rate_we), .en(1'b1),
    .limit(rate_q[CW-1:DW]), .term(pre_en));

  baud_stage #(.W(DW)) u_div (
    .clk(clk), .rst_n(rst_n), .clr(rate_we), .en(pre_en),
    .limit(rate_q[DW-1:0]), .term(tick16_o));

  baud_stage #(.W(BW)) u_bit (
    .clk(clk), .rst_n(rst_n), .clr(rate_we), .en(tick16_o),
    .limit(BIT_LAST), .term(bit_tick_o));

  // R5: bit strobe only with an oversampling strobe
  assert_bit_with_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick_o |-> tick16_o);

  // R3: zero word strobes every cycle
  assert_zero_word_every_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_q == '0) |-> tick16_o);

  // R4: no strobe in cycle 0 after a write unless the period is one
  assert_restart_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rate_we) && (rate_q != '0)) |-> !tick16_o);
endmodule

// File: tb/baud_tick_gen_test.sv
module baud_tick_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rate_we = 1'b0;
  logic [11:0] rate_wdata = '0;
  logic        tick16_o, bit_tick_o;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  baud_tick_gen uut (.clk(clk), .rst_n(rst_n), .rate_we(rate_we),
    .rate_wdata(rate_wdata), .tick16_o(tick16_o), .bit_tick_o(bit_tick_o));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // writes a word; returns at the negedge of cycle 0
  task automatic write_rate(input logic [11:0] w);
    @(negedge clk);
    rate_we = 1'b1; rate_wdata = w;
    @(negedge clk);
    rate_we = 1'b0;
  endtask

  // cycles from now until tick16 is high
  task automatic wait_tick(output int n);
    n = 0;
    while (!tick16_o && n < 70000) begin n++; @(negedge clk); end
  endtask

  task automatic test_period(input string req, input logic [11:0] w);
    int p, n;
    p = (int'(w[11:8]) + 1) * (int'(w[7:0]) + 1);
    write_rate(w);
    wait_tick(n);
    chk({req, " R1 R4 first strobe"}, n, p - 1);
    @(negedge clk);
    if (p > 1) chk({req, " R2 width"}, tick16_o, 0);
    wait_tick(n);
    chk({req, " R2 interval"}, n + 1, p);
  endtask

  task automatic test_bit(input logic [11:0] w);
    int p, n, t;
    p = (int'(w[11:8]) + 1) * (int'(w[7:0]) + 1);
    write_rate(w);
    n = 0; t = 0;
    while (!bit_tick_o && n < 70000) begin
      if (tick16_o) t++;
      n++; @(negedge clk);
    end
    chk("R5 bit strobe cycle", n, 16 * p - 1);
    chk("R5 strobe count before bit", t, 15);
    chk("R5 bit with tick", tick16_o, 1);
  endtask

  task automatic test_reset;
    int n;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R6 tick16 after reset", tick16_o, 1);
    chk("R6 bit low after reset", bit_tick_o, 0);
    n = 0;
    while (!bit_tick_o && n < 100) begin
      chk("R6 R3 tick16 each cycle", tick16_o, 1);
      n++; @(negedge clk);
    end
    chk("R6 first bit strobe", n, 15);
  endtask

  task automatic test_restart_midway;
    write_rate(12'h0_20);
    repeat (10) @(negedge clk);
    test_period("R4 midway", 12'h2_03);
  endtask

  initial begin
    #3000000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    test_reset();
    test_period("R3", 12'h000);
    test_period("div only", 12'h00F);
    test_period("pre only", 12'h500);
    test_period("both", 12'h3_07);
    test_restart_midway();
    test_bit(12'h002);
    test_bit(12'h1_01);
    test_period("R7 max", 12'hFFF);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule